// File: doc/BRIEF.md
# Register-Mapped Serial Port with Atomic Bit Aliases

This block is a byte-oriented asynchronous serial port that software drives through a small 32-bit register bus. Frames are one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. A divisor register sets the bit rate, and the receiver samples each bit near its middle using a tick that runs sixteen times per bit. Four-entry queues sit on both the transmit and receive sides. Status flags show whether the transmit queue is full, whether the transmitter is fully drained, whether received data is waiting and whether the receiver has overrun.

The control register and the status/control register each have two extra write-only addresses. Writing ones to one of them sets the chosen bits, and writing ones to the other clears them. Software can therefore change a single bit without a read-modify-write sequence. An overrun stops reception until software clears the flag. A break request holds the line low for one frame time and then clears itself.

Transmit states: TX_IDLE (line high), TX_START, TX_DATA, TX_STOP, TX_BREAK. TX_IDLE goes to TX_BREAK when a break is pending, and otherwise to TX_START when the transmitter is enabled and the queue holds a byte. Each of TX_START, TX_DATA (eight bits) and TX_STOP lasts sixteen ticks per bit. TX_STOP returns to TX_IDLE. TX_BREAK returns to TX_IDLE after ten bit times. Receive states: RX_IDLE goes to RX_START on a low line at a tick. RX_START goes to RX_DATA if the line is still low eight ticks later, and otherwise back to RX_IDLE. RX_DATA samples every sixteen ticks and moves to RX_STOP after eight bits. RX_STOP returns to RX_IDLE and keeps the byte only when the line is high. Clearing the module enable sends both machines to their idle states.

Top module: `mmio_uart`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x00000100 (only the drained flag, bit 8, set), the divisor register reads 0 and the line output is high.
- R2: Addresses 0x00 (control) and 0x10 (status) take direct writes. Base+0x8 sets, and base+0x4 clears, only the bits written as one. Control bit 15 is the module enable. Status bits 12 (receive enable), 11 (break request), 10 (transmit enable) and 1 (overrun) are writable. All other bits are unchanged.
- R3: Each bit lasts (D+1)*16 clock cycles, where D is the value at address 0x40. A frame is a low start bit, data bits 0 through 7, and a high stop bit. The line idles high.
- R4: A write to 0x20 queues byte [7:0]. The transmit queue holds 4 bytes, and status bit 9 reads 1 when it is full. A write while full is dropped, and the queued bytes are not disturbed.
- R5: Status bit 8 reads 1 only when the transmit queue is empty and no frame or break is on the line.
- R6: The receiver samples each bit at its middle. Status bit 0 reads 1 while received bytes wait. A read of 0x30 returns the oldest byte in [7:0] and removes it.
- R7: A frame whose stop bit reads low is discarded.
- R8: A byte that completes while the receive queue is full is lost and sets status bit 1. No further byte is received until software clears that bit.
- R9: A break request waits for the current frame to finish, drives the line low for 10 bit times, and then clears status bit 11 by itself.
- R10: Clearing the module enable empties both queues and returns both state machines to idle.
- R11: While transmit enable is 0, queued bytes stay queued and the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; on address 0x30 it removes a byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
Register updates become visible on the clock edge that takes the write, so the bench reads them back in its very next bus access. Read data is sampled one time unit after the address is driven, before the popping edge. Serial results take frame times: a loopback byte is complete about 9.5 bit times after its start edge plus two synchronizer cycles, so the bench waits well over a frame before polling. Line levels of a transmitted frame are sampled at bit midpoints, measured from the observed falling edge of the start bit. The break is checked deep inside its ten-bit window and again after it ends.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;
    localparam logic [7:0] A_CTRL     = 8'h00;
    localparam logic [7:0] A_CTRL_CLR = 8'h04;
    localparam logic [7:0] A_CTRL_SET = 8'h08;
    localparam logic [7:0] A_STAT     = 8'h10;
    localparam logic [7:0] A_STAT_CLR = 8'h14;
    localparam logic [7:0] A_STAT_SET = 8'h18;
    localparam logic [7:0] A_TXD      = 8'h20;
    localparam logic [7:0] A_RXD      = 8'h30;
    localparam logic [7:0] A_DIV      = 8'h40;

    localparam int B_EN    = 15;
    localparam int B_RXEN  = 12;
    localparam int B_BRK   = 11;
    localparam int B_TXEN  = 10;
    localparam int B_FULL  = 9;
    localparam int B_DRAIN = 8;
    localparam int B_OVR   = 1;
    localparam int B_AVAIL = 0;

    localparam int FRAME_BITS = 10;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_BREAK
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_state_t;
endpackage

// File: rtl/mmio_uart_tick.sv
module mmio_uart_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= divisor) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/mmio_uart_fifo.sv
module mmio_uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt_ptr(wr_q);
            if (do_pop)  rd_q <= nxt_ptr(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_q] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (full && $stable(rd_q))); // R4
endmodule

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx
    import mmio_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tx_go,
    input  logic       tick,
    input  logic       brk_req,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       brk_done,
    output logic       busy,
    output logic       txd
);
    tx_state_t  state_q, state_d;
    logic [3:0] sub_q, idx_q;
    logic [7:0] sh_q;
    logic       bit_end;

    assign bit_end = tick && (sub_q == 4'hF);

    always_comb begin
        state_d  = state_q;
        q_pop    = 1'b0;
        brk_done = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (brk_req) state_d = TX_BREAK;
                else if (tx_go && !q_empty) begin
                    state_d = TX_START;
                    q_pop   = 1'b1;
                end
            end
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && idx_q == 4'd7) state_d = TX_STOP;
            TX_STOP:  if (bit_end) state_d = TX_IDLE;
            TX_BREAK: if (bit_end && idx_q == 4'(FRAME_BITS - 1)) begin
                state_d  = TX_IDLE;
                brk_done = 1'b1;
            end
            default: state_d = TX_IDLE;
        endcase
        if (!run) begin
            state_d  = TX_IDLE;
            q_pop    = 1'b0;
            brk_done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            if (q_pop) sh_q <= q_data;
            if (state_d != state_q || state_q == TX_IDLE) begin
                sub_q <= '0;
                idx_q <= '0;
            end else if (tick) begin
                sub_q <= sub_q + 1'b1;
                if (sub_q == 4'hF) begin
                    idx_q <= idx_q + 1'b1;
                    if (state_q == TX_DATA) sh_q <= sh_q >> 1;
                end
            end
        end
    end

    always_comb begin
        busy = (state_q != TX_IDLE);
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_STOP:  txd = 1'b1;
            TX_BREAK: txd = 1'b0;
            default:  txd = 1'b1;
        endcase
    end

    AST_POP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> (!txd || !run)); // R3
endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx
    import mmio_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       rxd,
    output logic       byte_vld,
    output logic [7:0] byte_data
);
    rx_state_t  state_q, state_d;
    logic [3:0] sub_q, idx_q;
    logic [7:0] sh_q;
    logic       s1_q, s2_q;

    always_comb begin
        state_d  = state_q;
        byte_vld = 1'b0;
        unique case (state_q)
            RX_IDLE:  if (tick && !s2_q) state_d = RX_START;
            RX_START: if (tick && sub_q == 4'd7) state_d = s2_q ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && sub_q == 4'hF && idx_q == 4'd7) state_d = RX_STOP;
            RX_STOP:  if (tick && sub_q == 4'hF) begin
                state_d  = RX_IDLE;
                byte_vld = s2_q;
            end
            default: state_d = RX_IDLE;
        endcase
        if (!run) begin
            state_d  = RX_IDLE;
            byte_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
        end else begin
            s1_q    <= rxd;
            s2_q    <= s1_q;
            state_q <= state_d;
            if (state_q == RX_DATA && tick && sub_q == 4'hF)
                sh_q <= {s2_q, sh_q[7:1]};
            if (state_d != state_q || state_q == RX_IDLE) begin
                sub_q <= '0;
                idx_q <= '0;
            end else if (tick) begin
                sub_q <= sub_q + 1'b1;
                if (sub_q == 4'hF) idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign byte_data = sh_q;
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
    import mmio_uart_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int Q_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rxd,
    output logic        txd
);
    logic             en_q, rxen_q, brk_q, txen_q, ovr_q;
    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic             txf_push, txf_pop, txf_full, txf_empty;
    logic [7:0]       txf_dout;
    logic             rxf_push, rxf_pop, rxf_full, rxf_empty;
    logic [7:0]       rxf_dout;
    logic             rx_vld;
    logic [7:0]       rx_byte;
    logic             tx_busy, brk_done, drained;
    logic             w_ctrl, w_ctrl_c, w_ctrl_s, w_stat, w_stat_c, w_stat_s;
    wire              unused_wdata_hi = ^bus_wdata[31:DIV_W];

    assign w_ctrl   = bus_wr && bus_addr == A_CTRL;
    assign w_ctrl_c = bus_wr && bus_addr == A_CTRL_CLR;
    assign w_ctrl_s = bus_wr && bus_addr == A_CTRL_SET;
    assign w_stat   = bus_wr && bus_addr == A_STAT;
    assign w_stat_c = bus_wr && bus_addr == A_STAT_CLR;
    assign w_stat_s = bus_wr && bus_addr == A_STAT_SET;

    function automatic logic upd(input logic cur, input logic b,
                                 input logic wd, input logic wc, input logic ws);
        if (wd)            return b;
        else if (wc && b)  return 1'b0;
        else if (ws && b)  return 1'b1;
        return cur;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            rxen_q <= 1'b0;
            brk_q  <= 1'b0;
            txen_q <= 1'b0;
            ovr_q  <= 1'b0;
            div_q  <= '0;
        end else begin
            en_q   <= upd(en_q,   bus_wdata[B_EN],   w_ctrl, w_ctrl_c, w_ctrl_s);
            rxen_q <= upd(rxen_q, bus_wdata[B_RXEN], w_stat, w_stat_c, w_stat_s);
            txen_q <= upd(txen_q, bus_wdata[B_TXEN], w_stat, w_stat_c, w_stat_s);
            if (brk_done) brk_q <= 1'b0;
            else brk_q <= upd(brk_q, bus_wdata[B_BRK], w_stat, w_stat_c, w_stat_s);
            if (rx_vld && rxf_full) ovr_q <= 1'b1;
            else ovr_q <= upd(ovr_q, bus_wdata[B_OVR], w_stat, w_stat_c, w_stat_s);
            if (bus_wr && bus_addr == A_DIV) div_q <= bus_wdata[DIV_W-1:0];
        end
    end

    assign txf_push = bus_wr && bus_addr == A_TXD;
    assign rxf_pop  = bus_rd && bus_addr == A_RXD;
    assign rxf_push = rx_vld && !rxf_full;
    assign drained  = txf_empty && !tx_busy;

    mmio_uart_tick #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(en_q), .divisor(div_q), .tick(tick)
    );

    mmio_uart_fifo #(.W(8), .DEPTH(Q_DEPTH)) txq_i (
        .clk(clk), .rst_n(rst_n), .clr(!en_q),
        .push(txf_push), .din(bus_wdata[7:0]), .pop(txf_pop),
        .dout(txf_dout), .full(txf_full), .empty(txf_empty)
    );

    mmio_uart_fifo #(.W(8), .DEPTH(Q_DEPTH)) rxq_i (
        .clk(clk), .rst_n(rst_n), .clr(!en_q),
        .push(rxf_push), .din(rx_byte), .pop(rxf_pop),
        .dout(rxf_dout), .full(rxf_full), .empty(rxf_empty)
    );

    mmio_uart_tx tx_i (
        .clk(clk), .rst_n(rst_n), .run(en_q), .tx_go(txen_q), .tick(tick),
        .brk_req(brk_q), .q_empty(txf_empty), .q_data(txf_dout),
        .q_pop(txf_pop), .brk_done(brk_done), .busy(tx_busy), .txd(txd)
    );

    mmio_uart_rx rx_i (
        .clk(clk), .rst_n(rst_n), .run(en_q && rxen_q && !ovr_q), .tick(tick),
        .rxd(rxd), .byte_vld(rx_vld), .byte_data(rx_byte)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: bus_rdata[B_EN] = en_q;
            A_STAT: begin
                bus_rdata[B_RXEN]  = rxen_q;
                bus_rdata[B_BRK]   = brk_q;
                bus_rdata[B_TXEN]  = txen_q;
                bus_rdata[B_FULL]  = txf_full;
                bus_rdata[B_DRAIN] = drained;
                bus_rdata[B_OVR]   = ovr_q;
                bus_rdata[B_AVAIL] = !rxf_empty;
            end
            A_RXD: bus_rdata[7:0] = rxf_empty ? 8'h00 : rxf_dout;
            A_DIV: bus_rdata[DIV_W-1:0] = div_q;
            default: bus_rdata = '0;
        endcase
    end

    AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && rxf_full) |=> ovr_q); // R8
    AST_BRK_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
        brk_done |=> !brk_q); // R9
    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (txf_empty && rxf_empty)); // R10
endmodule

// File: tb/mmio_uart_tb_top.sv
module mmio_uart_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd;
    logic        drv_rx = 1'b1;
    logic        loop_en = 1'b0;
    logic        rxd;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;
    assign rxd = loop_en ? txd : drv_rx;

    mmio_uart dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd)
    );

    // stimulus byte [15:8], expected received byte [7:0] over loopback
    localparam logic [15:0] VEC [8] = '{
        16'h0000, 16'hFFFF, 16'h5555, 16'hAAAA,
        16'h0101, 16'h8080, 16'h3C3C, 16'hE7E7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_avail(output bit ok);
        logic [31:0] s;
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            rd(8'h10, s);
            if (s[0]) begin ok = 1'b1; break; end
        end
    endtask

    // drive one frame on the receive pin at divisor 0 (16 clocks per bit)
    task automatic send_frame(input logic [7:0] b, input logic stop);
        @(negedge clk);
        drv_rx = 1'b0; idle(16);
        for (int i = 0; i < 8; i++) begin drv_rx = b[i]; idle(16); end
        drv_rx = stop; idle(16);
        drv_rx = 1'b1;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic [9:0]  cap, expf;
        bit          ok;

        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h10, d); chk("R1 status", d, 32'h100);
        rd(8'h40, d); chk("R1 divisor", d, 32'h0);
        chk("R1 line", {31'b0, txd}, 32'h1);

        // R2 aliases
        wr(8'h08, 32'hFFFF_8000); rd(8'h00, d); chk("R2 ctrl set", d, 32'h8000);
        wr(8'h10, 32'h0000_1400); rd(8'h10, d); chk("R2 status direct", d, 32'h1500);
        wr(8'h14, 32'h0000_1000); rd(8'h10, d); chk("R2 status clr", d, 32'h0500);
        wr(8'h18, 32'h0000_1000); rd(8'h10, d); chk("R2 status set", d, 32'h1500);
        wr(8'h04, 32'h0000_0000); rd(8'h00, d); chk("R2 ctrl clr zero", d, 32'h8000);

        // R6 / R3 loopback vectors
        loop_en = 1'b1;
        foreach (VEC[k]) begin
            wr(8'h20, {24'h0, VEC[k][15:8]});
            idle(200);
            rd(8'h10, d); chk("R6 avail", {31'b0, d[0]}, 32'h1);
            rd(8'h30, d); chk("R6 loopback data", d, {24'h0, VEC[k][7:0]});
        end
        rd(8'h10, d); chk("R6 queue empty after reads", d, 32'h1500);

        // R3 bit period at divisor 2: 48 clocks per bit
        loop_en = 1'b0;
        wr(8'h40, 32'h2);
        wr(8'h20, 32'hA5);
        while (txd) @(negedge clk);
        idle(24);
        for (int b = 0; b < 10; b++) begin
            cap[b] = txd;
            if (b < 9) idle(48);
        end
        expf = {1'b1, 8'hA5, 1'b0};
        chk("R3 frame bits", {22'b0, cap}, {22'b0, expf});
        idle(60);
        rd(8'h10, d); chk("R5 drained after frame", {31'b0, d[8]}, 32'h1);
        wr(8'h40, 32'h0);

        // R4 / R5 full and dropped write
        loop_en = 1'b1;
        for (int i = 0; i < 5; i++) wr(8'h20, 32'h11 + i);
        rd(8'h10, d);
        chk("R4 full flag", {31'b0, d[9]}, 32'h1);
        chk("R5 not drained", {31'b0, d[8]}, 32'h0);
        wr(8'h20, 32'h16);
        for (int i = 0; i < 5; i++) begin
            wait_avail(ok);
            rd(8'h30, d); chk("R4 queued order", d, 32'h11 + i);
        end
        idle(400);
        rd(8'h10, d); chk("R4 dropped write not sent", d, 32'h1500);

        // R8 overrun
        for (int i = 0; i < 5; i++) wr(8'h20, 32'h21 + i);
        idle(1100);
        rd(8'h10, d); chk("R8 overrun set", d, 32'h1503);
        wr(8'h20, 32'h77);
        idle(250);
        for (int i = 0; i < 4; i++) begin
            rd(8'h30, d); chk("R8 kept bytes", d, 32'h21 + i);
        end
        rd(8'h10, d); chk("R8 halted while flagged", d, 32'h1502);
        wr(8'h14, 32'h2);
        rd(8'h10, d); chk("R8 cleared by alias", d, 32'h1500);
        wr(8'h20, 32'h88);
        idle(250);
        rd(8'h30, d); chk("R8 resumes", d, 32'h88);

        // R7 stop bit low
        loop_en = 1'b0;
        send_frame(8'h5A, 1'b0);
        idle(48);
        rd(8'h10, d); chk("R7 bad stop discarded", d, 32'h1500);
        send_frame(8'hC3, 1'b1);
        idle(40);
        rd(8'h30, d); chk("R7 good frame after", d, 32'hC3);

        // R9 break
        wr(8'h18, 32'h800);
        idle(4);
        chk("R9 line low early", {31'b0, txd}, 32'h0);
        idle(136);
        chk("R9 line low late", {31'b0, txd}, 32'h0);
        idle(40);
        chk("R9 line released", {31'b0, txd}, 32'h1);
        rd(8'h10, d); chk("R9 self clear", d, 32'h1500);

        // R11 transmit disabled
        wr(8'h14, 32'h400);
        for (int i = 0; i < 3; i++) wr(8'h20, 32'h31 + i);
        idle(20);
        chk("R11 line held high", {31'b0, txd}, 32'h1);
        send_frame(8'h3C, 1'b1);
        idle(40);
        rd(8'h10, d); chk("R11 bytes held", d, 32'h1001);

        // R10 flush on disable
        wr(8'h04, 32'h8000);
        rd(8'h10, d); chk("R10 queues flushed", d, 32'h1100);
        rd(8'h00, d); chk("R10 ctrl off", d, 32'h0);
        loop_en = 1'b1;
        wr(8'h08, 32'h8000);
        wr(8'h18, 32'h400);
        idle(300);
        rd(8'h10, d); chk("R10 nothing resent", d, 32'h1500);

        summary();
    end
endmodule